// File: doc/BRIEF.md
# Multi-Mode Serial Channel with Baud Timer

This block is a full-duplex serial channel. Each direction has one holding register in front of its shift register. In start-stop mode every bit lasts sixteen base ticks. The receiver oversamples the line and takes each bit at mid-bit. Software writes characters into the transmit holding register and reads complete characters from the receive buffer. Parity, framing and overrun conditions are reported on sticky flags.

The base tick comes from one of two sources. The first is an internal 16-bit down-counter that reloads from `reload`, giving one tick every `reload+1` clocks. The second is an external clock pin, where each rising edge is one tick. In clock-synchronous mode there are no start, stop, parity or address bits, each bit lasts two ticks, and the block drives a shift clock. In multiprocessor mode an address bit is added to the frame, and a hunt flag drops data frames until an address frame arrives.

Top module: `uart_mm`

## Requirements
- R1: The character length is `7 + L` without parity and `6 + L` with parity, where L is `len_sel`, and `len_sel = 3` behaves as 2. Received characters appear on `rx_data` LSB first, with every bit above the length reading zero.
- R2: In start-stop mode the line idles high. A frame is sent in this order: one low start bit, the data bits LSB first, the parity bit (if enabled), the address bit (if multiprocessor mode is on), and one high stop bit.
- R3: With `par_odd = 0` the parity bit makes the count of ones over data and parity even. With `par_odd = 1` it makes that count odd.
- R4: With the internal timer selected, one start-stop bit lasts exactly `16*(reload+1)` clock cycles.
- R5: With `ext_sel = 1`, each rising edge of `ext_clk` is one tick, so one start-stop bit lasts 16 `ext_clk` periods.
- R6: `tx_empty` is high while the transmit holding register is free. A `tx_wr` while it is occupied is ignored. A second character waits in the holding register and is sent after the first, in order.
- R7: `rx_full` is set when a character is accepted and cleared by a `rx_rd` pulse.
- R8: If a character completes while `rx_full` is still set, `oerr` is set and the new character is dropped, so `rx_data` keeps the old one. `err_clr` clears `perr`, `ferr` and `oerr`.
- R9: A stop bit sampled low sets `ferr`, and the character is still stored.
- R10: A received parity bit that disagrees with R3 sets `perr`.
- R11: A start bit that is low for less than half a bit time is rejected, and no character is produced. A longer low pulse is taken as a start bit.
- R12: In multiprocessor mode, while `hunt` is set, frames with address bit 0 are dropped. A frame with address bit 1 is stored with `rx_addr = 1` and clears `hunt`. `hunt_set` sets `hunt`.
- R13: In synchronous mode each data bit lasts two ticks, with `sck` low in the first tick and high in the second. `txd` holds the bit for both ticks. `rxd` is sampled where `sck` rises. The received character completes together with the last transmitted bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 1 = clock-synchronous mode, 0 = start-stop mode |
| ext_sel | input | 1 | 1 = ticks come from `ext_clk`, 0 = internal timer |
| ext_clk | input | 1 | External transfer clock |
| reload | input | 16 | Reload value of the internal timer |
| len_sel | input | 2 | Character length select |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | Odd parity when 1 |
| mp_en | input | 1 | Multiprocessor address-bit mode |
| tx_data | input | 9 | Character to send |
| tx_addr | input | 1 | Address bit to send in multiprocessor mode |
| tx_wr | input | 1 | Write pulse into the transmit holding register |
| tx_empty | output | 1 | Transmit holding register is free |
| tx_idle | output | 1 | Transmit shifter is idle |
| txd | output | 1 | Serial output |
| sck | output | 1 | Shift clock in synchronous mode |
| rxd | input | 1 | Serial input |
| rx_rd | input | 1 | Read pulse that frees the receive buffer |
| hunt_set | input | 1 | Sets the address-wait flag |
| err_clr | input | 1 | Clears the error flags |
| rx_data | output | 9 | Received character |
| rx_addr | output | 1 | Address bit of the received character |
| rx_full | output | 1 | Receive buffer holds an unread character |
| hunt | output | 1 | Waiting for an address frame |
| perr | output | 1 | Parity error flag |
| ferr | output | 1 | Framing error flag |
| oerr | output | 1 | Overrun error flag |

## Verification
A transmit frame starts on the first tick after the write lands in the holding register. Every output bit changes only on a tick. The bench therefore finds the falling start edge and samples each bit at the middle of its slot, 16k+8 ticks later. Received results settle about three clocks after the receiver samples the stop bit, at its mid-point, because `rxd` passes through a two-flop synchronizer. The bench reads `rx_full`, the data and the flags only once a full bit time has gone by after the stop bit. In synchronous mode it samples `txd` after `sck` has risen, and it changes `rxd` only after `sck` has fallen, which leaves a whole tick for the synchronizer.

// File: rtl/uart_mm.sv
module uart_mm #(
  parameter int TW = 16,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_mode,
  input  logic          ext_sel,
  input  logic          ext_clk,
  input  logic [TW-1:0] reload,
  input  logic [1:0]    len_sel,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          mp_en,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_addr,
  input  logic          tx_wr,
  output logic          tx_empty,
  output logic          tx_idle,
  output logic          txd,
  output logic          sck,
  input  logic          rxd,
  input  logic          rx_rd,
  input  logic          hunt_set,
  input  logic          err_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_addr,
  output logic          rx_full,
  output logic          hunt,
  output logic          perr,
  output logic          ferr,
  output logic          oerr
);
  localparam int FW = DW + 4;
  localparam int CW = $clog2(FW + 1);

  function automatic logic [DW-1:0] lenmask(input logic [CW-1:0] n);
    lenmask = '0;
    for (int i = 0; i < DW; i++) lenmask[i] = (i < int'(n));
  endfunction

  logic [CW-1:0] nd, flen, pix, mix;
  assign nd   = CW'(DW - 2 - int'(par_en)) + CW'(len_sel == 2'd3 ? 2 : int'(len_sel));
  assign flen = nd + CW'(2) + CW'(par_en) + CW'(mp_en);
  assign pix  = nd + CW'(1);
  assign mix  = pix + CW'(par_en);

  // tick source
  logic [TW-1:0] tcnt;
  logic [2:0]    es;
  logic [1:0]    rs_q;
  logic          rs, tick;
  assign rs   = rs_q[1];
  assign tick = ext_sel ? (es[1] & ~es[2]) : (tcnt == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tcnt <= '0;
      es   <= '0;
      rs_q <= 2'b11;
    end else begin
      tcnt <= (tcnt == '0) ? reload : tcnt - 1'b1;
      es   <= {es[1:0], ext_clk};
      rs_q <= {rs_q[0], rxd};
    end

  // transmitter
  logic [DW-1:0] th_data;
  logic          th_addr, tbusy;
  logic [FW-1:0] tsr, tframe;
  logic [CW-1:0] tbit, tlast;
  logic [3:0]    tsub, tsub_end;
  assign tlast    = sync_mode ? nd - CW'(1) : flen - CW'(1);
  assign tsub_end = sync_mode ? 4'd1 : 4'd15;

  always_comb begin
    tframe = '1;
    if (sync_mode) tframe[DW-1:0] = th_data;
    else begin
      tframe[0] = 1'b0;
      for (int i = 0; i < DW; i++) if (i < int'(nd)) tframe[i+1] = th_data[i];
      if (par_en) tframe[pix] = ^(th_data & lenmask(nd)) ^ par_odd;
      if (mp_en) tframe[mix] = th_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      th_data  <= '0;
      th_addr  <= 1'b0;
      tx_empty <= 1'b1;
      tsr      <= '1;
      tbusy    <= 1'b0;
      tbit     <= '0;
      tsub     <= '0;
    end else begin
      if (tx_wr && tx_empty) begin
        th_data  <= tx_data;
        th_addr  <= tx_addr;
        tx_empty <= 1'b0;
      end
      if (tick) begin
        if (!tbusy) begin
          if (!tx_empty) begin
            tsr      <= tframe;
            tbusy    <= 1'b1;
            tbit     <= '0;
            tsub     <= '0;
            tx_empty <= 1'b1;
          end
        end else if (tsub == tsub_end) begin
          tsub <= '0;
          tsr  <= {1'b1, tsr[FW-1:1]};
          tbit <= tbit + CW'(1);
          if (tbit == tlast) tbusy <= 1'b0;
        end else tsub <= tsub + 4'd1;
      end
    end

  assign tx_idle = !tbusy;
  assign txd     = tbusy ? tsr[0] : 1'b1;
  assign sck     = sync_mode & tbusy & tsub[0];

  // receiver
  logic          rbusy, rpar, rmp;
  logic [CW-1:0] rbit;
  logic [3:0]    rsub;
  logic [DW-1:0] rdat, fin;
  logic          a_smp, s_smp, done, d_perr, d_ferr, d_mp, keep, full_n;

  assign a_smp  = tick && rbusy && !sync_mode && rsub == 4'd8;
  assign s_smp  = tick && sync_mode && tbusy && tsub == 4'd0;
  assign done   = (a_smp && rbit == flen - CW'(1)) || (s_smp && tbit == nd - CW'(1));
  assign d_perr = par_en && !sync_mode && (^(rdat & lenmask(nd)) ^ par_odd ^ rpar);
  assign d_ferr = !sync_mode && !rs;
  assign d_mp   = mp_en && !sync_mode && rmp;
  assign keep   = !(hunt && mp_en && !sync_mode && !d_mp);
  assign full_n = rx_full & ~rx_rd;

  always_comb begin
    fin = rdat;
    if (s_smp) begin
      if (tbit == '0) fin = '0;
      fin[tbit] = rs;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rbusy <= 1'b0;
      rsub  <= '0;
      rbit  <= '0;
      rdat  <= '0;
      rpar  <= 1'b0;
      rmp   <= 1'b0;
    end else begin
      if (sync_mode) begin
        rbusy <= 1'b0;
        if (s_smp) rdat <= fin;
      end else if (tick) begin
        if (!rbusy) begin
          if (!rs) begin
            rbusy <= 1'b1;
            rsub  <= 4'd1;
            rbit  <= '0;
            rdat  <= '0;
            rpar  <= 1'b0;
            rmp   <= 1'b0;
          end
        end else begin
          rsub <= rsub + 4'd1;
          if (rsub == 4'd15) rbit <= rbit + CW'(1);
          if (rsub == 4'd8) begin
            if (rbit == '0 && rs) rbusy <= 1'b0;
            else if (rbit == flen - CW'(1)) rbusy <= 1'b0;
            else if (rbit != '0 && rbit <= nd) rdat[rbit - CW'(1)] <= rs;
            else if (par_en && rbit == pix) rpar <= rs;
            else if (rbit == mix) rmp <= rs;
          end
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_data <= '0;
      rx_addr <= 1'b0;
      rx_full <= 1'b0;
      hunt    <= 1'b0;
      perr    <= 1'b0;
      ferr    <= 1'b0;
      oerr    <= 1'b0;
    end else begin
      rx_full <= full_n;
      if (err_clr) begin
        perr <= 1'b0;
        ferr <= 1'b0;
        oerr <= 1'b0;
      end
      if (hunt_set) hunt <= 1'b1;
      if (done && keep) begin
        if (full_n) oerr <= 1'b1;
        else begin
          rx_data <= fin & lenmask(nd);
          rx_addr <= d_mp;
          rx_full <= 1'b1;
          if (d_perr) perr <= 1'b1;
          if (d_ferr) ferr <= 1'b1;
          if (d_mp) hunt <= 1'b0;
        end
      end
    end

  // R1
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> (rx_data & ~lenmask(nd)) == '0);
  // R8
  oerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oerr) |-> $past(rx_full));
  // R12
  hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hunt) |-> rx_addr && rx_full);
  // R13
  sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> sync_mode && $past(tick));
  // R6
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_idle) |-> $past(tick) && $past(!tx_empty));
endmodule

// File: tb/uart_mm_test.sv
module uart_mm_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_mode = 0, ext_sel = 0, ext_clk = 0;
  logic [15:0] reload = '0;
  logic [1:0] len_sel = '0;
  logic par_en = 0, par_odd = 0, mp_en = 0;
  logic [8:0] tx_data = '0;
  logic tx_addr = 0, tx_wr = 0, rx_rd = 0, hunt_set = 0, err_clr = 0;
  logic lb = 0, drv = 1;
  logic tx_empty, tx_idle, txd, sck, rxd, rx_addr, rx_full, hunt, perr, ferr, oerr;
  logic [8:0] rx_data;
  int checks = 0, fails = 0;

  assign rxd = lb ? txd : drv;

  uart_mm uut (.clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .ext_sel(ext_sel),
    .ext_clk(ext_clk), .reload(reload), .len_sel(len_sel), .par_en(par_en),
    .par_odd(par_odd), .mp_en(mp_en), .tx_data(tx_data), .tx_addr(tx_addr),
    .tx_wr(tx_wr), .tx_empty(tx_empty), .tx_idle(tx_idle), .txd(txd), .sck(sck),
    .rxd(rxd), .rx_rd(rx_rd), .hunt_set(hunt_set), .err_clr(err_clr),
    .rx_data(rx_data), .rx_addr(rx_addr), .rx_full(rx_full), .hunt(hunt),
    .perr(perr), .ferr(ferr), .oerr(oerr));

  always #10 clk = ~clk;
  always #80 ext_clk = ~ext_clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int ndof(input int pe, input int ls);
    return (pe != 0 ? 6 : 7) + (ls == 3 ? 2 : ls);
  endfunction

  function automatic int parof(input int d, input int n, input int po);
    int c = 0;
    for (int i = 0; i < n; i++) c += (d >> i) & 1;
    return (c % 2) ^ po;
  endfunction

  function automatic int fbit(input int k, input int d, input int a, input int pe,
                              input int po, input int mp, input int n);
    int j;
    if (k == 0) return 0;
    if (k <= n) return (d >> (k - 1)) & 1;
    j = k - n - 1;
    if (pe != 0) begin
      if (j == 0) return parof(d, n, po);
      j--;
    end
    if (mp != 0) begin
      if (j == 0) return a;
      j--;
    end
    return 1;
  endfunction

  task automatic pulse_wr(input int d, input int a);
    tx_data = 9'(d); tx_addr = a[0]; tx_wr = 1; cyc(1); tx_wr = 0;
  endtask

  task automatic pulse_rd();
    rx_rd = 1; cyc(1); rx_rd = 0;
  endtask

  task automatic pulse_clr();
    err_clr = 1; cyc(1); err_clr = 0;
  endtask

  task automatic wait_low();
    for (int g = 0; g < 5000 && txd; g++) cyc(1);
  endtask

  task automatic wait_full();
    for (int g = 0; g < 5000 && !rx_full; g++) cyc(1);
  endtask

  task automatic drive_frame(input int d, input int n, input int pb, input int mb,
                             input int sv);
    drv = 0; cyc(16);
    for (int i = 0; i < n; i++) begin drv = d[i]; cyc(16); end
    if (pb >= 0) begin drv = pb[0]; cyc(16); end
    if (mb >= 0) begin drv = mb[0]; cyc(16); end
    drv = sv[0]; cyc(16);
    drv = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n, d, a, cnt, fl, m;
    cyc(3); rst_n = 1; cyc(2);
    chk("R2 idle txd", txd, 1);
    chk("R6 tx_empty reset", tx_empty, 1);
    chk("R6 tx_idle reset", tx_idle, 1);
    chk("R7 rx_full reset", rx_full, 0);
    chk("R12 hunt reset", hunt, 0);
    chk("R8 flags reset", {perr, ferr, oerr}, 0);
    chk("R13 sck reset", sck, 0);

    // loopback sweep over length, parity, address mode
    lb = 1;
    for (int pe = 0; pe < 2; pe++)
      for (int ls = 0; ls < 4; ls++)
        for (int mp = 0; mp < 2; mp++)
          for (int v = 0; v < 3; v++) begin
            par_en = pe[0]; len_sel = ls[1:0]; mp_en = mp[0]; par_odd = v[0];
            n = ndof(pe, ls);
            m = (1 << n) - 1;
            d = (v == 0 ? 'h1A5 : v == 1 ? 'h05A : 'h1FF) ^ (ls * 37);
            a = v & 1;
            fl = n + 2 + pe + mp;
            pulse_wr(d, a);
            wait_low();
            cyc(8);
            for (int k = 0; k < fl; k++) begin
              if (pe != 0 && k == n + 1)
                chk("R3 parity bit", txd, fbit(k, d, a, pe, v & 1, mp, n));
              else
                chk("R2 frame bit", txd, fbit(k, d, a, pe, v & 1, mp, n));
              cyc(16);
            end
            cyc(2);
            chk("R7 rx_full set", rx_full, 1);
            chk("R1 rx_data", rx_data, d & m);
            chk("R12 rx_addr", rx_addr, mp != 0 ? a : 0);
            chk("R10 no perr", perr, 0);
            chk("R9 no ferr", ferr, 0);
            pulse_rd();
            chk("R7 rx_full cleared", rx_full, 0);
          end
    par_odd = 0; mp_en = 0; par_en = 0;

    // R4 internal timer bit length
    reload = 16'd5; len_sel = 2'd2;
    pulse_wr('h1FF, 0);
    wait_low();
    cnt = 0;
    while (!txd && cnt < 1000) begin cyc(1); cnt++; end
    chk("R4 bit time", cnt, 96);
    cyc(96 * 11);
    chk("R4 rx_data", rx_data, 'h1FF);
    pulse_rd();

    // R5 external clock
    ext_sel = 1;
    pulse_wr('h0FB, 0);
    wait_low();
    cnt = 0;
    while (!txd && cnt < 1000) begin cyc(1); cnt++; end
    chk("R5 ext bit time", cnt, 128);
    cyc(128 * 11);
    chk("R5 rx_data", rx_data, 'h0FB);
    pulse_rd();
    ext_sel = 0; reload = '0;

    // R6 double buffering, ignored write
    len_sel = 2'd1;
    pulse_wr('h3C, 0);
    cyc(3);
    chk("R6 holding freed", tx_empty, 1);
    pulse_wr('hA5, 0);
    chk("R6 holding occupied", tx_empty, 0);
    pulse_wr('h11, 0);
    wait_full();
    chk("R6 first char", rx_data, 'h3C);
    pulse_rd();
    wait_full();
    chk("R6 second char", rx_data, 'hA5);
    pulse_rd();
    cyc(400);
    chk("R6 ignored write", rx_full, 0);
    lb = 0;

    // R8 overrun
    drive_frame('h12, 8, -1, -1, 1); cyc(20);
    drive_frame('h34, 8, -1, -1, 1); cyc(20);
    chk("R8 oerr", oerr, 1);
    chk("R8 old data kept", rx_data, 'h12);
    pulse_clr();
    chk("R8 oerr cleared", oerr, 0);
    pulse_rd();

    // R9 framing error
    drive_frame('h5A, 8, -1, -1, 0); cyc(40);
    chk("R9 ferr", ferr, 1);
    chk("R9 data stored", rx_data, 'h5A);
    chk("R9 rx_full", rx_full, 1);
    pulse_clr(); pulse_rd();

    // R10 parity error
    par_en = 1; len_sel = 2'd2;
    drive_frame('h0F, 8, 1, -1, 1); cyc(20);
    chk("R10 even mismatch", perr, 1);
    pulse_clr(); pulse_rd();
    par_odd = 1;
    drive_frame('h0F, 8, 1, -1, 1); cyc(20);
    chk("R10 odd match", perr, 0);
    chk("R10 data", rx_data, 'h0F);
    pulse_rd();
    par_en = 0; par_odd = 0; len_sel = 2'd1;

    // R11 glitch
    drv = 0; cyc(5); drv = 1; cyc(300);
    chk("R11 glitch rejected", rx_full, 0);
    chk("R11 no ferr", ferr, 0);
    drv = 0; cyc(12); drv = 1; cyc(300);
    chk("R11 long low accepted", rx_full, 1);
    chk("R11 long low data", rx_data, 'hFF);
    pulse_rd();

    // R12 multiprocessor
    mp_en = 1;
    hunt_set = 1; cyc(1); hunt_set = 0;
    chk("R12 hunt set", hunt, 1);
    drive_frame('h55, 8, -1, 0, 1); cyc(20);
    chk("R12 data dropped", rx_full, 0);
    chk("R12 still hunting", hunt, 1);
    drive_frame('h12, 8, -1, 1, 1); cyc(20);
    chk("R12 address stored", rx_full, 1);
    chk("R12 address flag", rx_addr, 1);
    chk("R12 address data", rx_data, 'h12);
    chk("R12 hunt cleared", hunt, 0);
    pulse_rd();
    drive_frame('h77, 8, -1, 0, 1); cyc(20);
    chk("R12 data accepted", rx_full, 1);
    chk("R12 data flag", rx_addr, 0);
    chk("R12 data value", rx_data, 'h77);
    pulse_rd();
    mp_en = 0;

    // R13 synchronous mode
    sync_mode = 1; reload = 16'd3;
    cyc(5);
    chk("R13 sck idle", sck, 0);
    drv = 0;
    pulse_wr('hC9, 0);
    for (int k = 0; k < 8; k++) begin
      for (int g = 0; g < 200 && !sck; g++) cyc(1);
      chk("R13 txd bit", txd, ('hC9 >> k) & 1);
      for (int g = 0; g < 200 && sck; g++) cyc(1);
      drv = (('h36 >> (k + 1)) & 1) != 0;
    end
    cyc(10);
    chk("R13 rx_full", rx_full, 1);
    chk("R13 rx_data", rx_data, 'h36);
    chk("R13 tx idle", tx_idle, 1);
    pulse_rd();
    sync_mode = 0; drv = 1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule